// File: doc/BRIEF.md
# Multi-Address SMBus EEPROM Bank

This block is a two-wire serial bus target that behaves like a row of up to eight small serial EEPROMs. It answers on a run of consecutive 7-bit bus addresses. Every address owns its own 256-byte window of one shared memory. Device `k` of the bank responds at `BASE_ADDR + k`, and its byte `p` lives at memory index `k*256 + p`.

Each device keeps its own 8-bit byte pointer. In a write transaction, the first data byte sets that pointer. Every further byte is stored at the pointer, and the pointer then steps forward. A read transaction returns bytes starting at the pointer and advances it after each byte. A controller can set the pointer with a short write and then issue a repeated START into a read.

The bus pins are open-drain. The block samples SCL and SDA and drives only a pull-low enable for SDA. A side port fills the memory before traffic starts, and any byte it does not write stays zero.

Top module: `smbee_bank`

## Requirements
- R1: An address byte carries the 7-bit address MSB first, followed by a direction bit (1 = read). The target ACKs by pulling SDA low during the ninth clock, and only for addresses `BASE_ADDR + k` with `k < NUM_DEV`. For any other address it leaves SDA released for the whole transaction, so the bits of a read all come back as 1.
- R2: A write on the preload port at index `i` sets the byte that device `i / 256` returns at pointer `i % 256`.
- R3: The first data byte of a write transaction (data bits MSB first) loads the byte pointer of the addressed device.
- R4: Each later byte of the same write is stored at the pointer, and the pointer then increments modulo 256, so a write that starts at 0xFE continues at 0xFF and then 0x00.
- R5: A read returns the byte at the pointer, MSB first, and then increments the pointer modulo 256. A controller ACK asks for the next byte.
- R6: After reset, every pointer is 0, every memory byte is 0 and SDA is released.
- R7: Each device has its own pointer. A write or read at one address leaves the pointers of the other addresses unchanged.
- R8: A write that carries only the pointer byte moves the pointer and changes no memory byte.
- R9: The target ACKs the pointer byte and every data byte of a write.
- R10: After the controller NACKs a read byte, the target leaves SDA released. A STOP or a START also makes it release SDA.
- R11: After a pointer-only write followed by a repeated START and a read address, the read begins at the newly loaded pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the bus pins are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level seen on the bus clock line |
| sda_i | input | 1 | Level seen on the bus data line |
| sda_oe_o | output | 1 | High pulls the data line low |
| init_we_i | input | 1 | Preload write strobe |
| init_addr_i | input | MEM_AW | Preload byte index, `device*256 + offset` |
| init_data_i | input | 8 | Preload byte value |

## Verification
The assertions assume the following about the inputs:
- SCL is driven only by the controller, and each of its levels lasts longer than the synchroniser delay plus one cycle.
- SDA changes while SCL is high only to form a START or a STOP.
- The preload port is used only while no transfer is moving a pointer.

The bench keeps to all three. It holds every SCL quarter-period for eight clocks and changes its own SDA drive a quarter-period after each falling SCL edge. It finishes the whole preload before the first START. It issues STOP or repeated START only when the target has released SDA, that is, after a write ACK slot or a NACKed read byte.

// File: rtl/smbee_pkg.sv
`timescale 1ns/1ps
package smbee_pkg;
   localparam int BYTE_W    = 8;
   localparam int WIN_BYTES = 256;

   typedef enum logic [2:0] {
      LNK_IDLE,
      LNK_ADDR,
      LNK_AACK,
      LNK_WR,
      LNK_WACK,
      LNK_RD,
      LNK_RACK
   } link_state_t;
endpackage

// File: rtl/smbee_sync.sv
`timescale 1ns/1ps
// Two-wire input conditioning: multi-stage synchroniser plus edge and
// START/STOP detection on the synchronised levels.
module smbee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_chain_q;
   logic [STAGES-1:0] sda_chain_q;
   logic              scl_prev_q;
   logic              sda_prev_q;
   logic              scl_s;
   logic              sda_s;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_chain_q <= '1;
         sda_chain_q <= '1;
         scl_prev_q  <= 1'b1;
         sda_prev_q  <= 1'b1;
      end else begin
         scl_chain_q <= {scl_chain_q[STAGES-2:0], scl_i};
         sda_chain_q <= {sda_chain_q[STAGES-2:0], sda_i};
         scl_prev_q  <= scl_s;
         sda_prev_q  <= sda_s;
      end
   end

   assign scl_s      = scl_chain_q[STAGES-1];
   assign sda_s      = sda_chain_q[STAGES-1];
   assign sda_s_o    = sda_s;
   assign scl_rise_o = scl_s & ~scl_prev_q;
   assign scl_fall_o = ~scl_s & scl_prev_q;
   // data line edges while the clock line stays high
   assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
   assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/smbee_decode.sv
`timescale 1ns/1ps
// Address window compare: one comparator per device of the bank.
module smbee_decode #(
   parameter int         NUM_DEV   = 8,
   parameter int         DEV_W     = 3,
   parameter logic [6:0] BASE_ADDR = 7'h50
) (
   input  logic [6:0]       addr_i,
   output logic             hit_o,
   output logic [DEV_W-1:0] dev_o
);
   if (NUM_DEV == 1) begin : g_single
      assign hit_o = (addr_i == BASE_ADDR);
      assign dev_o = '0;
   end else begin : g_multi
      logic [NUM_DEV-1:0] hit_vec;
      for (genvar k = 0; k < NUM_DEV; k++) begin : g_cmp
         assign hit_vec[k] = (addr_i == 7'(int'(BASE_ADDR) + k));
      end
      always_comb begin
         dev_o = '0;
         for (int k = 0; k < NUM_DEV; k++) begin
            if (hit_vec[k]) dev_o = DEV_W'(k);
         end
      end
      assign hit_o = |hit_vec;
   end
endmodule

// File: rtl/smbee_link.sv
`timescale 1ns/1ps
// Bit/byte sequencer: address phase, write bytes with ACK, read bytes with
// controller ACK/NACK. Issues pointer and memory strobes to the store.
module smbee_link
   import smbee_pkg::*;
#(
   parameter int DEV_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             sda_s_i,
   input  logic             hit_i,
   input  logic [DEV_W-1:0] hit_dev_i,
   input  logic [7:0]       rd_data_i,
   output logic [6:0]       addr_o,
   output logic             sda_oe_o,
   output logic [DEV_W-1:0] dev_o,
   output logic             ptr_ld_o,
   output logic             wr_en_o,
   output logic             rd_adv_o,
   output logic [7:0]       data_o
);
   localparam int              CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   link_state_t      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [7:0]       rx_q;
   logic [7:0]       tx_q;
   logic [DEV_W-1:0] dev_q;
   logic             rw_q;
   logic             first_q;
   logic             more_q;
   logic             oe_q;
   logic             bus_evt;
   logic             commit;
   logic             fetch;

   assign bus_evt = start_i | stop_i;
   assign commit  = (state_q == LNK_WR) & scl_fall_i & (cnt_q == FULL) & ~bus_evt;
   assign fetch   = scl_fall_i & ~bus_evt &
                    (((state_q == LNK_AACK) & rw_q) | ((state_q == LNK_RACK) & more_q));

   assign ptr_ld_o = commit & first_q;
   assign wr_en_o  = commit & ~first_q;
   assign rd_adv_o = fetch;
   assign data_o   = rx_q;
   assign dev_o    = dev_q;
   assign addr_o   = rx_q[7:1];
   assign sda_oe_o = oe_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LNK_IDLE;
         cnt_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         dev_q   <= '0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         more_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (start_i) begin
         state_q <= LNK_ADDR;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (stop_i) begin
         state_q <= LNK_IDLE;
         oe_q    <= 1'b0;
      end else if (fetch) begin
         tx_q    <= {rd_data_i[6:0], 1'b0};
         oe_q    <= ~rd_data_i[7];
         cnt_q   <= CNT_W'(1);
         state_q <= LNK_RD;
      end else begin
         unique case (state_q)
            LNK_ADDR: begin
               if (scl_rise_i) begin
                  rx_q  <= {rx_q[6:0], sda_s_i};
                  cnt_q <= cnt_q + CNT_W'(1);
               end else if (scl_fall_i && cnt_q == FULL) begin
                  if (hit_i) begin
                     oe_q    <= 1'b1;
                     dev_q   <= hit_dev_i;
                     rw_q    <= rx_q[0];
                     state_q <= LNK_AACK;
                  end else begin
                     state_q <= LNK_IDLE;
                  end
               end
            end
            LNK_AACK: begin
               if (scl_fall_i) begin
                  oe_q    <= 1'b0;
                  cnt_q   <= '0;
                  first_q <= 1'b1;
                  state_q <= LNK_WR;
               end
            end
            LNK_WR: begin
               if (scl_rise_i) begin
                  rx_q  <= {rx_q[6:0], sda_s_i};
                  cnt_q <= cnt_q + CNT_W'(1);
               end else if (scl_fall_i && cnt_q == FULL) begin
                  oe_q    <= 1'b1;
                  first_q <= 1'b0;
                  state_q <= LNK_WACK;
               end
            end
            LNK_WACK: begin
               if (scl_fall_i) begin
                  oe_q    <= 1'b0;
                  cnt_q   <= '0;
                  state_q <= LNK_WR;
               end
            end
            LNK_RD: begin
               if (scl_fall_i) begin
                  if (cnt_q == FULL) begin
                     oe_q    <= 1'b0;
                     state_q <= LNK_RACK;
                  end else begin
                     oe_q  <= ~tx_q[7];
                     tx_q  <= {tx_q[6:0], 1'b0};
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            LNK_RACK: begin
               if (scl_rise_i) begin
                  more_q <= ~sda_s_i;
               end else if (scl_fall_i) begin
                  state_q <= LNK_IDLE;
               end
            end
            default: ;
         endcase
      end
   end

   assert_stop_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !sda_oe_o);
   assert_start_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> !sda_oe_o);
   assert_nack_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LNK_RACK && scl_fall_i && !more_q && !bus_evt) |=> (!sda_oe_o && state_q == LNK_IDLE));
   assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LNK_IDLE) |-> !sda_oe_o);
   assert_wack_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LNK_WACK) |-> sda_oe_o);
   assert_read_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == LNK_RD || state_q == LNK_RACK) |-> rw_q);
endmodule

// File: rtl/smbee_store.sv
`timescale 1ns/1ps
// Shared byte array with one pointer register per device window.
module smbee_store #(
   parameter int NUM_DEV = 8,
   parameter int DEV_W   = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              init_we_i,
   input  logic [DEV_W+7:0]  init_addr_i,
   input  logic [7:0]        init_data_i,
   input  logic [DEV_W-1:0]  dev_sel_i,
   input  logic              ptr_ld_i,
   input  logic              wr_en_i,
   input  logic              rd_adv_i,
   input  logic [7:0]        data_i,
   output logic [7:0]        rd_data_o
);
   localparam int             AW      = DEV_W + 8;
   localparam int             DEPTH   = NUM_DEV * 256;
   localparam logic [AW:0]    DEPTH_V = (AW+1)'(DEPTH);

   logic [7:0]    mem_q [DEPTH];
   logic [7:0]    ptr_q [NUM_DEV];
   logic [7:0]    ptr_cur;
   logic [AW-1:0] bus_idx;
   logic          bus_ok;
   logic          init_ok;

   always_comb begin
      ptr_cur = '0;
      for (int k = 0; k < NUM_DEV; k++) begin
         if (dev_sel_i == DEV_W'(k)) ptr_cur = ptr_q[k];
      end
   end

   assign bus_idx   = {dev_sel_i, ptr_cur};
   assign bus_ok    = ({1'b0, bus_idx} < DEPTH_V);
   assign init_ok   = ({1'b0, init_addr_i} < DEPTH_V);
   assign rd_data_o = bus_ok ? mem_q[bus_idx] : 8'h00;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (init_we_i && init_ok) begin
         mem_q[init_addr_i] <= init_data_i;
      end else if (wr_en_i && bus_ok) begin
         mem_q[bus_idx] <= data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < NUM_DEV; k++) ptr_q[k] <= '0;
      end else begin
         for (int k = 0; k < NUM_DEV; k++) begin
            if (dev_sel_i == DEV_W'(k)) begin
               if (ptr_ld_i)                  ptr_q[k] <= data_i;
               else if (wr_en_i || rd_adv_i)  ptr_q[k] <= ptr_q[k] + 8'd1;
            end
         end
      end
   end

   for (genvar k = 0; k < NUM_DEV; k++) begin : g_ptr_chk
      assert_ptr_iso_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (dev_sel_i != DEV_W'(k)) |=> $stable(ptr_q[k]));
      assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (dev_sel_i == DEV_W'(k) && (wr_en_i || rd_adv_i) && !ptr_ld_i)
            |=> (ptr_q[k] == $past(ptr_q[k]) + 8'd1));
   end

   assert_init_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_we_i |-> !(wr_en_i || ptr_ld_i || rd_adv_i));
endmodule

// File: rtl/smbee_bank.sv
`timescale 1ns/1ps
// Bank of EEPROM-like targets on consecutive addresses sharing one array.
module smbee_bank
   import smbee_pkg::*;
#(
   parameter int         NUM_DEV     = 8,
   parameter logic [6:0] BASE_ADDR   = 7'h50,
   parameter int         SYNC_STAGES = 2,
   localparam int        DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int        MEM_AW      = DEV_W + 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              init_we_i,
   input  logic [MEM_AW-1:0] init_addr_i,
   input  logic [7:0]        init_data_i
);
   if (NUM_DEV < 1 || NUM_DEV > 8) begin : g_bad_num_dev
      initial $fatal(1, "smbee_bank: NUM_DEV must lie in 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "smbee_bank: SYNC_STAGES must be at least 2");
   end
   if (int'(BASE_ADDR) + NUM_DEV > 128) begin : g_bad_base
      initial $fatal(1, "smbee_bank: address run leaves the 7-bit space");
   end

   logic             sda_s;
   logic             scl_rise;
   logic             scl_fall;
   logic             start_evt;
   logic             stop_evt;
   logic [6:0]       addr;
   logic             hit;
   logic [DEV_W-1:0] hit_dev;
   logic [DEV_W-1:0] dev_sel;
   logic             ptr_ld;
   logic             wr_en;
   logic             rd_adv;
   logic [7:0]       bus_byte;
   logic [7:0]       rd_data;

   smbee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_s_o    (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_evt),
      .stop_o     (stop_evt)
   );

   smbee_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .BASE_ADDR(BASE_ADDR)) u_decode (
      .addr_i (addr),
      .hit_o  (hit),
      .dev_o  (hit_dev)
   );

   smbee_link #(.DEV_W(DEV_W)) u_link (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_evt),
      .stop_i     (stop_evt),
      .sda_s_i    (sda_s),
      .hit_i      (hit),
      .hit_dev_i  (hit_dev),
      .rd_data_i  (rd_data),
      .addr_o     (addr),
      .sda_oe_o   (sda_oe_o),
      .dev_o      (dev_sel),
      .ptr_ld_o   (ptr_ld),
      .wr_en_o    (wr_en),
      .rd_adv_o   (rd_adv),
      .data_o     (bus_byte)
   );

   smbee_store #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .init_we_i   (init_we_i),
      .init_addr_i (init_addr_i),
      .init_data_i (init_data_i),
      .dev_sel_i   (dev_sel),
      .ptr_ld_i    (ptr_ld),
      .wr_en_i     (wr_en),
      .rd_adv_i    (rd_adv),
      .data_i      (bus_byte),
      .rd_data_o   (rd_data)
   );
endmodule

// File: tb/smbee_bank_bench.sv
`timescale 1ns/1ps
module smbee_bank_bench;
   localparam int NDEV    = 4;
   localparam int Q       = 8;
   localparam int IMG_LEN = 300;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       scl;
   logic       m_low;
   logic       init_we;
   logic [9:0] init_addr;
   logic [7:0] init_data;
   logic       sda_oe;
   wire        sda_line;

   int checks = 0;
   int fails  = 0;
   logic [7:0] model [0:1023];
   int         ptr_m [0:3];

   assign sda_line = ~(m_low | sda_oe);

   always #2.5 clk = ~clk;

   smbee_bank #(.NUM_DEV(NDEV)) u_smbee_bank (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_line),
      .sda_oe_o    (sda_oe),
      .init_we_i   (init_we),
      .init_addr_i (init_addr),
      .init_data_i (init_data)
   );

   function automatic logic [7:0] img(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic bus_start();
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b1; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_low = ~b[i]; tick(Q);
         scl = 1'b1;    tick(2*Q);
         scl = 1'b0;    tick(Q);
      end
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      ack = ~sda_line;
      tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q);
         scl = 1'b0;
      end
      tick(Q);
      m_low = give_ack; tick(Q);
      scl = 1'b1;       tick(2*Q);
      scl = 1'b0;       tick(Q);
      m_low = 1'b0;
   endtask

   // write: address, pointer byte, then n data bytes
   task automatic wr_seq(input int dev, input logic [7:0] p, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input bit do_stop, input string tag);
      logic       ack;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      bus_start();
      send_byte({7'(8'h50 + dev), 1'b0}, ack);
      chk("R1", int'(ack), 1);
      send_byte(p, ack);
      chk("R9", int'(ack), 1);
      ptr_m[dev] = int'(p);
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], ack);
         chk("R9", int'(ack), 1);
         model[dev*256 + ptr_m[dev]] = d[i];
         ptr_m[dev] = (ptr_m[dev] + 1) % 256;
      end
      if (do_stop) bus_stop();
      if (tag == "") chk("R3", 0, 0);
   endtask

   task automatic read_seq(input int dev, input int n, input string tag);
      logic       ack;
      logic [7:0] b;
      bus_start();
      send_byte({7'(8'h50 + dev), 1'b1}, ack);
      chk("R1", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, b);
         chk(tag, int'(b), int'(model[dev*256 + ptr_m[dev]]));
         ptr_m[dev] = (ptr_m[dev] + 1) % 256;
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] b;
      rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
      init_we = 1'b0; init_addr = '0; init_data = '0;
      for (int i = 0; i < 1024; i++) model[i] = 8'h00;
      for (int k = 0; k < 4; k++) ptr_m[k] = 0;
      tick(5);
      chk("R6", int'(sda_oe), 0);
      rst_n = 1'b1;
      tick(5);
      chk("R6", int'(sda_oe), 0);

      // preload image (R2)
      for (int i = 0; i < IMG_LEN; i++) begin
         init_we = 1'b1; init_addr = 10'(i); init_data = img(i);
         model[i] = img(i);
         tick(1);
      end
      init_we = 1'b0;
      tick(Q);

      // R1: address sweep, write direction, nothing after the address
      for (int a = 8'h48; a <= 8'h5F; a++) begin
         bus_start();
         send_byte({7'(a), 1'b0}, ack);
         bus_stop();
         chk("R1", int'(ack), int'(a >= 8'h50 && a < 8'h50 + NDEV));
      end

      // R1: NACKed read address leaves the data line high
      bus_start();
      send_byte({7'h56, 1'b1}, ack);
      chk("R1", int'(ack), 0);
      recv_byte(1'b0, b);
      chk("R1", int'(b), 8'hFF);
      bus_stop();

      // R6/R2/R5: first reads start at pointer 0 in each window
      read_seq(0, 2, "R6");
      read_seq(1, 1, "R2");
      read_seq(2, 1, "R6");
      read_seq(3, 1, "R6");

      // R4: block write across the 0xFF -> 0x00 wrap
      wr_seq(2, 8'hFE, 3, 8'hA1, 8'hB2, 8'hC3, 1'b1, "R4");
      // R11: pointer-only write, repeated start, read four bytes
      wr_seq(2, 8'hFE, 0, 8'h00, 8'h00, 8'h00, 1'b0, "R3");
      read_seq(2, 4, "R11");

      // R7: window 1 pointer untouched by window 2 traffic
      read_seq(1, 1, "R7");

      // R8: pointer-only writes do not alter memory
      wr_seq(3, 8'h10, 1, 8'h5A, 8'h00, 8'h00, 1'b1, "R4");
      wr_seq(3, 8'h10, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R8");
      wr_seq(0, 8'h20, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R8");
      read_seq(3, 2, "R8");
      read_seq(0, 1, "R8");

      // R5: full-window sequential read from 0x80 with wrap, then one more
      wr_seq(3, 8'h80, 0, 8'h00, 8'h00, 8'h00, 1'b1, "R3");
      read_seq(3, 256, "R5");
      read_seq(3, 1, "R5");

      // R10: line released after the controller NACKs, and after STOP
      bus_start();
      send_byte({7'h50, 1'b1}, ack);
      chk("R1", int'(ack), 1);
      recv_byte(1'b0, b);
      chk("R5", int'(b), int'(model[ptr_m[0]]));
      ptr_m[0] = (ptr_m[0] + 1) % 256;
      tick(Q);
      chk("R10", int'(sda_oe), 0);
      bus_stop();
      tick(Q);
      chk("R10", int'(sda_oe), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule